// File: doc/BRIEF.md
# Paged Memory Stream Port

This block lets a host walk through one of five parameter memories, one byte at a time, through a single data strobe. The host first writes a mode code that picks the memory, a 16-bit start address and a 16-bit byte count. It then issues read or write strobes. Each accepted strobe touches the memory at the current address, moves the address up by one and takes one off the remaining count.

The five memories have different depths, all derived from three size parameters: input width 41, hidden width 100 and output width 200. They are the hidden weight matrix, the hidden bias vector, the output weight matrix, the output bias vector and the input buffer. Weight and bias bytes are signed 8-bit values. The port carries them as raw bytes.

Each memory has a one-cycle read latency. The port therefore prefetches the byte at the current address after every settings change and after every accepted byte. The host must leave at least two idle cycles after each strobe or settings write before the next strobe.

Strobes are refused in two situations, and in both cases the address and count are left unchanged:
- When the count is zero, the strobe is refused silently.
- When the address lies outside the selected memory, or the mode code is unknown, the strobe is refused and an error flag is raised.

Top module: `pgstream_port`

## Requirements
- R1: After synchronous active-low reset, the address, the count, the error flag and the read data are all 0, and no memory enable is asserted.
- R2: Mode codes select targets as follows, with `mem_en_o` bit k belonging to target k:

  | Mode code | Target k | Memory | Depth |
  |---|---|---|---|
  | 1 | 0 | hidden weights | 4100 |
  | 2 | 1 | hidden bias | 100 |
  | 3 | 2 | output weights | 20000 |
  | 4 | 3 | output bias | 200 |
  | 5 | 4 | input buffer | 41 |

  An accepted strobe asserts only the enable bit of the selected target.
- R3: An accepted write strobe drives, in the same cycle, the selected enable, `mem_we_o`=1, `mem_addr_o` equal to the current address and `mem_wdata_o` equal to the host byte. From the next cycle the address is one higher and the count one lower.
- R4: While the count is non-zero and the address is inside the selected target, `rdata_o` shows the stored byte at the current address. This holds from the second cycle after any settings write or accepted strobe. An accepted read strobe then advances the address and count as in R3.
- R5: With a count of 0, read and write strobes are ignored: no enable is asserted, the address and count are unchanged, the error flag is not raised and `rdata_o` is 0.
- R6: With a non-zero count, a strobe at an address equal to or above the target depth is ignored. No enable is asserted, the address and count stay as they were, and `err_o` becomes 1 in the next cycle. `rdata_o` reads 0 while the address is out of range.
- R7: A mode code outside 1..5 behaves as in R6 for every strobe with a non-zero count.
- R8: The settings select `cfg_we_i` has bit 0 for the mode (low byte of `cfg_wdata_i`), bit 1 for the address and bit 2 for the count. A settings write replaces only the selected settings, keeps the others and clears `err_o`. A strobe in the same cycle as a settings write is dropped.
- R9: A cycle with both `rd_i` and `wr_i` high is treated as a write.
- R10: In a burst that runs past the end of a target, every byte up to the last address is accepted and the first byte beyond it is refused as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 3 | Settings write select: bit0 mode, bit1 address, bit2 count |
| cfg_wdata_i | input | 16 | Settings value (mode uses bits 7:0) |
| rd_i | input | 1 | Data read strobe |
| wr_i | input | 1 | Data write strobe |
| wdata_i | input | 8 | Host byte for a write strobe |
| rdata_o | output | 8 | Prefetched byte at the current address, or 0 |
| addr_o | output | 16 | Current stream address |
| len_o | output | 16 | Remaining byte count |
| err_o | output | 1 | Refused-access flag, cleared by any settings write |
| mem_en_o | output | 5 | Per-target memory enable |
| mem_we_o | output | 1 | Memory write enable (shared) |
| mem_addr_o | output | 16 | Memory address (shared) |
| mem_wdata_o | output | 8 | Memory write data (shared) |
| mem_rdata_i | input | 40 | Per-target read data, target k in bits 8k+7:8k, valid one cycle after enable |

## Verification
A corrupted address or count register appears on `addr_o` and `len_o` in the very next cycle, and on `mem_addr_o` at the next strobe. A wrong target decode shows at once as the wrong enable bit, or as an error flag raised where none belongs. A broken prefetch path shows as a wrong byte on `rdata_o` two cycles after the event that should have refreshed it. The bench's memory model keeps every written byte, so a write sent to the wrong place is caught when that location is read back.

// File: rtl/pgstream_pkg.sv
`timescale 1ns/1ps
// Shared constants for the paged stream port.
// Assumes target order: hidden weights, hidden bias, output weights,
// output bias, input buffer; mode code k+1 selects target k.
package pgstream_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int MODE_W  = 8;
    localparam int NUM_TGT = 5;
    localparam int CFG_W   = 3;

    // Bit positions inside the settings write select.
    localparam int CFG_MODE_BIT = 0;
    localparam int CFG_ADDR_BIT = 1;
    localparam int CFG_LEN_BIT  = 2;

    // Depth of target k, derived from the three layer widths.
    function automatic int unsigned tgt_depth(input int k, input int n_in,
                                              input int n_hid, input int n_out);
        case (k)
            0:       return n_hid * n_in;
            1:       return n_hid;
            2:       return n_out * n_hid;
            3:       return n_out;
            default: return n_in;
        endcase
    endfunction
endpackage

// File: rtl/pgstream_decode.sv
`timescale 1ns/1ps
// Target decoder: turns the mode code and current address into a
// one-hot "address fits target k" vector and a "mode is known" flag.
// Assumes each target depth fits in the address width.
module pgstream_decode
    import pgstream_pkg::*;
#(
    parameter int N_IN  = 41,
    parameter int N_HID = 100,
    parameter int N_OUT = 200,
    parameter int NT    = NUM_TGT,
    parameter int AW    = ADDR_W,
    parameter int MW    = MODE_W
) (
    input  logic [MW-1:0] mode_i,
    input  logic [AW-1:0] addr_i,
    output logic [NT-1:0] fit_o,
    output logic          known_o
);
    logic [NT-1:0] hit;

    // One comparator pair per target, depth computed from the widths.
    for (genvar k = 0; k < NT; k++) begin : g_tgt
        localparam int unsigned DEPTH = tgt_depth(k, N_IN, N_HID, N_OUT);
        localparam logic [MW-1:0] CODE = MW'(k + 1);
        assign hit[k]   = (mode_i == CODE);
        assign fit_o[k] = hit[k] && (32'(addr_i) < DEPTH);
    end

    assign known_o = |hit;

    // R2
    always_comb begin
        fit_known_chk: assert ((fit_o == '0) || (known_o && $onehot(fit_o)));
    end
endmodule

// File: rtl/pgstream_cursor.sv
`timescale 1ns/1ps
// Settings and cursor registers: mode, address, remaining count and the
// refused-access flag. Settings writes win over strobes in the same cycle.
// Assumes the top only raises take/bad when no settings write is present.
module pgstream_cursor
    import pgstream_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int MW = MODE_W,
    parameter int CW = CFG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_we_i,
    input  logic [AW-1:0] cfg_wdata_i,
    input  logic          acc_req_i,
    input  logic          acc_take_i,
    input  logic          acc_bad_i,
    output logic [MW-1:0] mode_o,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] len_o,
    output logic          err_o,
    output logic          len_nz_o
);
    logic [MW-1:0] mode_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] len_q;
    logic          err_q;
    logic          cfg_any;

    assign cfg_any = |cfg_we_i;

    // Mode register: loaded from the low byte of the settings value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (cfg_we_i[CFG_MODE_BIT])
            mode_q <= cfg_wdata_i[MW-1:0];
    end

    // Address register: loaded by settings, advanced by accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (cfg_we_i[CFG_ADDR_BIT])
            addr_q <= cfg_wdata_i;
        else if (acc_take_i && !cfg_any)
            addr_q <= addr_q + AW'(1);
    end

    // Count register: loaded by settings, reduced by accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= '0;
        else if (cfg_we_i[CFG_LEN_BIT])
            len_q <= cfg_wdata_i;
        else if (acc_take_i && !cfg_any)
            len_q <= len_q - AW'(1);
    end

    // Error flag: set by refused strobes, cleared by any settings write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (cfg_any)
            err_q <= 1'b0;
        else if (acc_bad_i)
            err_q <= 1'b1;
    end

    assign mode_o   = mode_q;
    assign addr_o   = addr_q;
    assign len_o    = len_q;
    assign err_o    = err_q;
    assign len_nz_o = (len_q != '0);

    // R3
    len_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_take_i |=> (len_q == $past(len_q) - AW'(1)) && (addr_q == $past(addr_q) + AW'(1)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_i && !len_nz_o) |=> $stable(addr_q) && $stable(len_q) && ($past(err_q) || !err_q));

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(acc_bad_i));

    // R8
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_any |=> !err_q);
endmodule

// File: rtl/pgstream_memport.sv
`timescale 1ns/1ps
// Memory port and read buffer. Drives the shared address/data and the
// per-target enables for accepted strobes and for prefetch reads, then
// captures the one-cycle-late read data into a byte buffer.
// Assumes no strobe arrives in the two cycles after a kick.
module pgstream_memport
    import pgstream_pkg::*;
#(
    parameter int NT = NUM_TGT,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick_i,
    input  logic             take_i,
    input  logic             we_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [NT-1:0]    fit_i,
    input  logic             ready_i,
    output logic [NT-1:0]    mem_en_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic [NT*DW-1:0] mem_rdata_i,
    output logic [DW-1:0]    rdata_o
);
    logic                   pf_req_q;
    logic                   issue;
    logic                   cap_q;
    logic [NT-1:0]          cap_sel_q;
    logic [NT-1:0][DW-1:0]  lane;
    logic [DW-1:0]          picked;
    logic [DW-1:0]          rbuf_q;

    // Prefetch request: raised the cycle after any settings change or byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pf_req_q <= 1'b0;
        else
            pf_req_q <= kick_i;
    end

    assign issue = pf_req_q && (|fit_i) && !take_i;

    // Capture tracker: remembers which target a prefetch read went to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= 1'b0;
            cap_sel_q <= '0;
        end else begin
            cap_q <= issue;
            if (issue)
                cap_sel_q <= fit_i;
        end
    end

    // Read lane gating per target.
    for (genvar k = 0; k < NT; k++) begin : g_lane
        assign lane[k] = cap_sel_q[k] ? mem_rdata_i[k*DW +: DW] : '0;
    end

    // OR-merge of the gated lanes.
    always_comb begin
        picked = '0;
        for (int k = 0; k < NT; k++)
            picked = picked | lane[k];
    end

    // Read buffer: holds the prefetched byte until the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rbuf_q <= '0;
        else if (cap_q)
            rbuf_q <= picked;
    end

    // Shared memory-side drive for strobes and prefetches.
    always_comb begin
        mem_en_o    = (take_i || issue) ? fit_i : '0;
        mem_we_o    = take_i && we_i;
        mem_addr_o  = addr_i;
        mem_wdata_o = (take_i && we_i) ? wdata_i : '0;
    end

    assign rdata_o = ready_i ? rbuf_q : '0;

    // R2
    en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_en_o));

    // R3
    we_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_en_o != '0));

    // R4
    cap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en_o != '0 && !mem_we_o) |=> cap_q || $past(take_i));
endmodule

// File: rtl/pgstream_port.sv
`timescale 1ns/1ps
// Paged memory stream port: one byte-wide stream in front of five
// parameter memories selected by mode code, with auto-advancing address
// and a remaining-count limit. Assumes the host leaves two idle cycles
// after every strobe or settings write.
module pgstream_port
    import pgstream_pkg::*;
#(
    parameter int N_IN  = 41,
    parameter int N_HID = 100,
    parameter int N_OUT = 200,
    parameter int NT    = NUM_TGT,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int MW    = MODE_W,
    parameter int CW    = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cfg_we_i,
    input  logic [AW-1:0]    cfg_wdata_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic [AW-1:0]    addr_o,
    output logic [AW-1:0]    len_o,
    output logic             err_o,
    output logic [NT-1:0]    mem_en_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic [NT*DW-1:0] mem_rdata_i
);
    logic [MW-1:0] mode;
    logic [AW-1:0] addr;
    logic [NT-1:0] fit;
    logic          known;
    logic          len_nz;
    logic          acc_req;
    logic          acc_take;
    logic          acc_bad;
    logic          kick;

    // Strobe classification: settings writes drop a same-cycle strobe.
    always_comb begin
        acc_req  = (rd_i || wr_i) && (cfg_we_i == '0);
        acc_take = acc_req && len_nz && (|fit);
        acc_bad  = acc_req && len_nz && !(|fit);
        kick     = (cfg_we_i != '0) || acc_take;
    end

    pgstream_decode #(
        .N_IN (N_IN),
        .N_HID(N_HID),
        .N_OUT(N_OUT),
        .NT   (NT),
        .AW   (AW),
        .MW   (MW)
    ) decode_i (
        .mode_i (mode),
        .addr_i (addr),
        .fit_o  (fit),
        .known_o(known)
    );

    pgstream_cursor #(
        .AW(AW),
        .MW(MW),
        .CW(CW)
    ) cursor_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we_i),
        .cfg_wdata_i(cfg_wdata_i),
        .acc_req_i  (acc_req),
        .acc_take_i (acc_take),
        .acc_bad_i  (acc_bad),
        .mode_o     (mode),
        .addr_o     (addr),
        .len_o      (len_o),
        .err_o      (err_o),
        .len_nz_o   (len_nz)
    );

    pgstream_memport #(
        .NT(NT),
        .AW(AW),
        .DW(DW)
    ) memport_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_i     (kick),
        .take_i     (acc_take),
        .we_i       (wr_i),
        .wdata_i    (wdata_i),
        .addr_i     (addr),
        .fit_i      (fit),
        .ready_i    (len_nz && (|fit)),
        .mem_en_o   (mem_en_o),
        .mem_we_o   (mem_we_o),
        .mem_addr_o (mem_addr_o),
        .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i),
        .rdata_o    (rdata_o)
    );

    assign addr_o = addr;

    // R7
    unknown_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && len_nz && !known) |-> (mem_en_o == '0) ##1 err_o);
endmodule

// File: tb/pgstream_port_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (integers plus an associative memory
// store) compared against the port on every clock, plus scenario checks.
module pgstream_port_tb_top;
    localparam int NT = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cfg_we;
    logic [15:0] cfg_wdata;
    logic        rd, wr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [15:0] addr_o, len_o;
    logic        err_o;
    logic [4:0]  mem_en;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [39:0] mem_rdata = '0;

    always #10 clk = ~clk;

    pgstream_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
        .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
        .addr_o(addr_o), .len_o(len_o), .err_o(err_o),
        .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int depth [NT] = '{4100, 100, 20000, 200, 41};
    byte unsigned store [int];

    int m_mode, m_addr, m_len, quiet;
    bit m_err;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int peek(input int t, input int a);
        int k = t * 65536 + a;
        if (store.exists(k)) return int'(store[k]);
        return (t * 37 + a * 13 + 5) & 255;
    endfunction

    function automatic int m_tgt();
        if (m_mode >= 1 && m_mode <= 5) return m_mode - 1;
        return -1;
    endfunction

    function automatic bit m_fit();
        int t = m_tgt();
        return (t >= 0) && (m_addr < depth[t]);
    endfunction

    // Memory model: one-cycle read latency, writes stored in the map.
    always @(posedge clk) begin
        for (int t = 0; t < NT; t++) begin
            if (mem_en[t]) begin
                if (mem_we) store[t * 65536 + int'(mem_addr)] = mem_wdata;
                else mem_rdata[t*8 +: 8] <= 8'(peek(t, int'(mem_addr)));
            end
        end
    end

    // Reference model of the port state.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_addr = 0; m_len = 0; m_err = 0; quiet = 0;
        end else if (cfg_we != 0) begin
            if (cfg_we[0]) m_mode = int'(cfg_wdata[7:0]);
            if (cfg_we[1]) m_addr = int'(cfg_wdata);
            if (cfg_we[2]) m_len  = int'(cfg_wdata);
            m_err = 0; quiet = 0;
        end else if (rd || wr) begin
            quiet = 0;
            if (m_len != 0) begin
                if (m_fit()) begin
                    m_addr = (m_addr + 1) & 65535;
                    m_len  = m_len - 1;
                end else m_err = 1;
            end
        end else if (quiet < 100) quiet++;
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 addr", int'(addr_o), m_addr);
            chk("R3 len", int'(len_o), m_len);
            chk("R6 err", int'(err_o), int'(m_err));
            if (quiet >= 2)
                chk("R4 rdata", int'(rdata), (m_len != 0 && m_fit()) ? peek(m_tgt(), m_addr) : 0);
            if ((rd || wr) && cfg_we == 0) begin
                if (m_len != 0 && m_fit()) begin
                    chk("R2 enable", int'(mem_en), 1 << m_tgt());
                    chk("R3 mem_addr", int'(mem_addr), m_addr);
                    chk("R9 mem_we", int'(mem_we), int'(wr));
                    if (wr) chk("R3 mem_wdata", int'(mem_wdata), int'(wdata));
                end else if (m_len == 0) chk("R5 no enable", int'(mem_en), 0);
                else if (m_tgt() < 0)   chk("R7 no enable", int'(mem_en), 0);
                else                    chk("R6 no enable", int'(mem_en), 0);
            end
        end
    end

    // Finish: two idle edges after the sampled edge, back at edge+2.
    task automatic settle();
        @(posedge clk); #2;
        cfg_we = '0; rd = 0; wr = 0;
        repeat (2) @(posedge clk);
        #2;
    endtask

    task automatic cfg(input int mask, input int val);
        cfg_we = 3'(mask); cfg_wdata = 16'(val);
        settle();
    endtask

    task automatic setup(input int mode, input int a, input int n);
        cfg(1, mode); cfg(2, a); cfg(4, n);
    endtask

    task automatic acc(input bit r, input bit w, input int d, output int seen);
        seen = int'(rdata);
        rd = r; wr = w; wdata = 8'(d);
        settle();
    endtask

    initial begin
        int v;
        rst_n = 0; cfg_we = '0; cfg_wdata = '0; rd = 0; wr = 0; wdata = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1: reset state
        chk("R1 addr", int'(addr_o), 0);
        chk("R1 len", int'(len_o), 0);
        chk("R1 err", int'(err_o), 0);
        chk("R1 rdata", int'(rdata), 0);
        chk("R1 enable", int'(mem_en), 0);
        repeat (2) @(posedge clk);
        #2;

        // R3: write burst into the input buffer
        setup(5, 0, 4);
        acc(0, 1, 11, v); acc(0, 1, 22, v); acc(0, 1, 33, v); acc(0, 1, 44, v);
        chk("R3 addr after burst", int'(addr_o), 4);
        chk("R3 len after burst", int'(len_o), 0);

        // R4: read back, past the written bytes
        setup(5, 0, 6);
        acc(1, 0, 0, v); chk("R4 first byte", v, 11);
        acc(1, 0, 0, v); acc(1, 0, 0, v);
        acc(1, 0, 0, v); chk("R4 fourth byte", v, 44);
        acc(1, 0, 0, v); chk("R4 unwritten byte", v, peek(4, 4));
        acc(1, 0, 0, v);

        // R5: count exhausted, strobes ignored
        acc(1, 0, 0, v);
        acc(0, 1, 99, v);
        chk("R5 addr held", int'(addr_o), 6);
        chk("R5 no error", int'(err_o), 0);
        chk("R5 rdata zero", int'(rdata), 0);
        cfg(4, 1);
        chk("R5 write ignored", int'(rdata), (4 * 37 + 6 * 13 + 5) & 255);

        // R6/R10: burst runs off the end of the hidden bias
        setup(2, 98, 5);
        acc(1, 0, 0, v); acc(1, 0, 0, v); acc(1, 0, 0, v);
        chk("R10 addr at end", int'(addr_o), 100);
        chk("R10 len left", int'(len_o), 3);
        chk("R6 err set", int'(err_o), 1);
        chk("R6 rdata zero", int'(rdata), 0);

        // R8: count rewrite keeps address, clears error
        cfg(4, 7);
        chk("R8 err cleared", int'(err_o), 0);
        chk("R8 addr kept", int'(addr_o), 100);
        chk("R8 len replaced", int'(len_o), 7);
        // R8: strobe dropped when it meets a settings write
        rd = 1; cfg(2, 5);
        chk("R8 strobe dropped addr", int'(addr_o), 5);
        chk("R8 strobe dropped len", int'(len_o), 7);

        // R7: unknown mode codes
        cfg(1, 0);
        acc(1, 0, 0, v);
        chk("R7 mode 0 err", int'(err_o), 1);
        chk("R7 mode 0 addr", int'(addr_o), 5);
        cfg(1, 6);
        acc(0, 1, 3, v);
        chk("R7 mode 6 err", int'(err_o), 1);
        chk("R7 mode 6 len", int'(len_o), 7);

        // R2: last address of every target, then one beyond
        for (int t = 0; t < NT; t++) begin
            setup(t + 1, depth[t] - 1, 2);
            acc(1, 0, 0, v);
            chk("R2 last byte", v, peek(t, depth[t] - 1));
            acc(1, 0, 0, v);
            chk("R2 beyond end err", int'(err_o), 1);
            chk("R2 beyond end addr", int'(addr_o), depth[t]);
        end

        // R9: read and write together act as a write
        setup(4, 10, 1);
        acc(1, 1, 90, v);
        chk("R9 stored", peek(3, 10), 90);

        // R10: long write burst across the end of the hidden weights
        setup(1, 4090, 20);
        for (int i = 0; i < 12; i++) acc(0, 1, i + 1, v);
        chk("R10 addr", int'(addr_o), 4100);
        chk("R10 len", int'(len_o), 10);
        chk("R10 err", int'(err_o), 1);
        chk("R10 last stored", peek(0, 4099), 10);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule